// File: doc/BRIEF.md
# Amplifier Output Diagnostic Sequencer

This block schedules the load checks of a bridge-driven audio output stage and keeps the resulting fault state. Analog sensing sits outside it. Each check result arrives as a digital flag, qualified by a strobe. Over-current and over-temperature arrive as level flags that are watched on every cycle.

A fixed run of checks starts on its own after reset. The output stage is held in shutdown until that run ends. After that, a run starts on a rising edge of the enable control bit, either once or repeatedly. In repeated mode, each later run starts after a programmable count of clock cycles and leaves out the open-load check.

Any detected problem turns the output stage off. It also pulls an active-low fault flag, unless the matching mask bit is set. Both stay latched until the clear bit makes a 0-to-1 transition.

Top module: `diag_fault_seq`

## Requirements
- R1: After reset, `amp_sd` is 1 and the checks run in the order rail short (`test_step`=1), outputs shorted together (`test_step`=2), open load (`test_step`=3), whatever the level of `diag_en`. `amp_sd` falls on the edge where the run ends (`test_step` returns to 0).
- R2: A 0-to-1 transition of `diag_clr` during the power-up run ends that run on the next edge: `test_step`=0 and `amp_sd`=0.
- R3: A step moves to the next step on an edge where `res_valid` is 1. If `res_valid` stays 0, the step moves on after `TMO_CYC` cycles, and the timeout records no fault.
- R4: With the block idle, a 0-to-1 transition of `diag_en` starts a full three-step run. A steady high level starts nothing, and transitions that occur while a run is busy are dropped.
- R5: When `diag_cont` is 0 at the starting transition, the run happens once. `diag_en` must fall and rise again before another run starts.
- R6: When `diag_cont` is 1 at the starting transition, each run end is followed by `PER_CYC` idle cycles and then a new run of steps 1 and 2 only. The repetition stops for good when `diag_cont` or `diag_en` is 0, when a fault is detected, or when `diag_clr` rises.
- R7: A strobe with the current step's own result flag high (step 1 `res_rail`, step 2 `res_short`, step 3 `res_open`) sets `out_dis` and ends the run at once.
- R8: `test_mask` bit 0 masks the shorted-outputs check, bit 1 masks open load, bit 2 masks rail short, bit 3 masks over-current and bit 4 masks over-temperature. An unmasked fault drives `fault_n` to 0. A masked fault still sets `out_dis` but leaves `fault_n` at 1.
- R9: `res_ocp` and `res_otp` are acted on in every cycle, including while idle with `diag_en`=0.
- R10: `fault_n`=0 and `out_dis`=1 stay latched after the cause has gone and after later runs that pass.
- R11: Only a 0-to-1 transition of `diag_clr` clears `fault_n` and `out_dis`, and it also cancels repetition. That clear wins over a fault seen in the same cycle, and a steady high `diag_clr` clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| diag_en | input | 1 | Check enable; a rising edge starts a run |
| diag_cont | input | 1 | 1 selects repeated runs |
| diag_clr | input | 1 | Rising edge clears latched faults |
| test_mask | input | 5 | Per-check fault-flag mask |
| res_valid | input | 1 | Strobe qualifying the step result flags |
| res_rail | input | 1 | Output-to-rail short seen |
| res_short | input | 1 | Outputs shorted together |
| res_open | input | 1 | No load seen |
| res_ocp | input | 1 | Over-current level |
| res_otp | input | 1 | Over-temperature level |
| fault_n | output | 1 | Latched fault flag, active low |
| out_dis | output | 1 | Output stage disable, latched |
| amp_sd | output | 1 | Shutdown hold during power-up run |
| test_step | output | 2 | Active step: 0 idle, 1 rail, 2 shorted, 3 open |

## Verification
The bench tries several run patterns, and each one separates behaviours that a simpler design would merge:
- Clean strobes against timeouts, to tell strobe-driven stepping from counter-driven stepping.
- One-shot against repeated runs, with `diag_en` held high, to show edge arming rather than level arming.
- Repeated runs, to confirm the shortened two-step run.
- Failing strobes on each step with masks set and clear, to show that the flag and the disable are separate.
- Monitor faults while idle, a held clear level, and a clear that coincides with a fault, which separate edge clearing from level clearing and pin down the clear's priority.

A behavioural model built from integers predicts every output on each clock.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAIL = 2'd1,
    ST_PAIR = 2'd2,
    ST_OPEN = 2'd3
  } step_e;

  localparam int MK_PAIR = 0;
  localparam int MK_OPEN = 1;
  localparam int MK_RAIL = 2;
  localparam int MK_OCP  = 3;
  localparam int MK_OTP  = 4;
  localparam int NMASK   = 5;

  // result flag owned by the active step
  function automatic logic step_result(step_e s, logic rail, logic pair, logic open_ld);
    case (s)
      ST_RAIL: return rail;
      ST_PAIR: return pair;
      ST_OPEN: return open_ld;
      default: return 1'b0;
    endcase
  endfunction

  // mask bit owned by the active step
  function automatic logic step_masked(step_e s, logic [NMASK-1:0] m);
    case (s)
      ST_RAIL: return m[MK_RAIL];
      ST_PAIR: return m[MK_PAIR];
      ST_OPEN: return m[MK_OPEN];
      default: return 1'b1;
    endcase
  endfunction

  // successor step; open-load only in full runs
  function automatic step_e step_after(step_e s, logic with_open);
    case (s)
      ST_RAIL: return ST_PAIR;
      ST_PAIR: return with_open ? ST_OPEN : ST_IDLE;
      default: return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/diag_edge.sv
module diag_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/diag_cnt.sv
module diag_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + W'(1);
  end

  assign hit = (cnt_q == LAST);
endmodule

// File: rtl/diag_fault_seq.sv
module diag_fault_seq
  import diag_pkg::*;
#(
  parameter int TMO_CYC = 1000,
  parameter int PER_CYC = 15_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diag_en,
  input  logic             diag_cont,
  input  logic             diag_clr,
  input  logic [NMASK-1:0] test_mask,
  input  logic             res_valid,
  input  logic             res_rail,
  input  logic             res_short,
  input  logic             res_open,
  input  logic             res_ocp,
  input  logic             res_otp,
  output logic             fault_n,
  output logic             out_dis,
  output logic             amp_sd,
  output logic [1:0]       test_step
);
  localparam int NEDGE = 2;

  step_e step_q;
  logic  boot_q, open_q, per_q, fault_q, dis_q;

  // named internal events
  logic [NEDGE-1:0] lvl, rise;
  logic en_rise, clr_rise;
  logic step_run, step_done, step_hit, mon_hit, detect, flag_set;
  logic tmo_hit, per_hit, per_fire, cancel;
  logic tmo_clr, per_clr;
  step_e step_nx;

  assign lvl = {diag_clr, diag_en};

  for (genvar gi = 0; gi < NEDGE; gi++) begin : g_edge
    diag_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl(lvl[gi]), .rise(rise[gi]));
  end

  assign en_rise  = rise[0];
  assign clr_rise = rise[1];

  assign step_run  = (step_q != ST_IDLE);
  assign step_done = step_run & (res_valid | tmo_hit);
  assign step_hit  = step_run & res_valid & step_result(step_q, res_rail, res_short, res_open);
  assign mon_hit   = res_ocp | res_otp;
  assign detect    = step_hit | mon_hit;
  assign flag_set  = (step_hit & ~step_masked(step_q, test_mask))
                   | (res_ocp & ~test_mask[MK_OCP])
                   | (res_otp & ~test_mask[MK_OTP]);
  assign cancel    = ~diag_cont | ~diag_en;
  assign per_fire  = ~step_run & per_q & per_hit & ~cancel;
  assign step_nx   = step_after(step_q, open_q);

  assign tmo_clr = clr_rise | detect | ~step_run | step_done;
  assign per_clr = clr_rise | detect | step_run | en_rise | per_fire;

  diag_cnt #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .inc(1'b1), .hit(tmo_hit)
  );

  diag_cnt #(.LIMIT(PER_CYC)) u_per (
    .clk(clk), .rst_n(rst_n), .clr(per_clr), .inc(per_q), .hit(per_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_RAIL;
      boot_q  <= 1'b1;
      open_q  <= 1'b1;
      per_q   <= 1'b0;
      fault_q <= 1'b0;
      dis_q   <= 1'b0;
    end else if (clr_rise) begin
      step_q  <= ST_IDLE;
      boot_q  <= 1'b0;
      per_q   <= 1'b0;
      fault_q <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      if (flag_set) fault_q <= 1'b1;
      if (detect)   dis_q   <= 1'b1;
      if (detect) begin
        step_q <= ST_IDLE;
        boot_q <= 1'b0;
        per_q  <= 1'b0;
      end else if (step_run) begin
        if (step_done) begin
          step_q <= step_nx;
          if (step_nx == ST_IDLE) boot_q <= 1'b0;
        end
        if (cancel) per_q <= 1'b0;
      end else if (en_rise) begin
        step_q <= ST_RAIL;
        open_q <= 1'b1;
        per_q  <= diag_cont;
      end else begin
        if (per_fire) begin
          step_q <= ST_RAIL;
          open_q <= 1'b0;
        end
        if (cancel) per_q <= 1'b0;
      end
    end
  end

  assign fault_n   = ~fault_q;
  assign out_dis   = dis_q;
  assign amp_sd    = boot_q;
  assign test_step = step_q;
endmodule

// File: rtl/diag_fault_seq_chk.sv
module diag_fault_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] test_mask,
  input logic       res_ocp,
  input logic       res_otp,
  input logic       fault_n,
  input logic       out_dis,
  input logic       amp_sd,
  input logic [1:0] test_step,
  input logic       clr_rise
);
  a_r1_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    amp_sd |-> (test_step != 2'd0));

  a_r9_ocp_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ocp && !clr_rise) |=> out_dis);

  a_r8_otp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (res_otp && !test_mask[4] && !clr_rise) |=> !fault_n);

  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_rise) |=> !fault_n);

  a_r10_dis_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dis && !clr_rise) |=> out_dis);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> (fault_n && !out_dis && test_step == 2'd0 && !amp_sd));
endmodule

bind diag_fault_seq diag_fault_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_mask(test_mask), .res_ocp(res_ocp),
  .res_otp(res_otp), .fault_n(fault_n), .out_dis(out_dis), .amp_sd(amp_sd),
  .test_step(test_step), .clr_rise(clr_rise)
);

// File: tb/sim_diag_fault_seq.sv
module sim_diag_fault_seq;
  localparam int TMO = 8;
  localparam int PER = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic diag_en = 1'b0, diag_cont = 1'b0, diag_clr = 1'b0;
  logic [4:0] test_mask = 5'd0;
  logic res_valid = 1'b0, res_rail = 1'b0, res_short = 1'b0, res_open = 1'b0;
  logic res_ocp = 1'b0, res_otp = 1'b0;
  logic fault_n, out_dis, amp_sd;
  logic [1:0] test_step;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  diag_fault_seq #(.TMO_CYC(TMO), .PER_CYC(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .diag_cont(diag_cont),
    .diag_clr(diag_clr), .test_mask(test_mask), .res_valid(res_valid),
    .res_rail(res_rail), .res_short(res_short), .res_open(res_open),
    .res_ocp(res_ocp), .res_otp(res_otp), .fault_n(fault_n),
    .out_dis(out_dis), .amp_sd(amp_sd), .test_step(test_step)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_step, m_t, m_p, nt, np;
  bit  m_boot, m_open, m_per, m_fault, m_dis, m_en_d, m_clr_d;
  bit  er, cr, run, res, msk, hit, det, fl, done, cancel, fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 1; m_boot = 1; m_open = 1; m_per = 0; m_fault = 0; m_dis = 0;
      m_t = 0; m_p = 0; m_en_d = 0; m_clr_d = 0;
    end else begin
      er = diag_en && !m_en_d;
      cr = diag_clr && !m_clr_d;
      run = (m_step != 0);
      case (m_step)
        1: begin res = res_rail;  msk = test_mask[2]; end
        2: begin res = res_short; msk = test_mask[0]; end
        3: begin res = res_open;  msk = test_mask[1]; end
        default: begin res = 0; msk = 1; end
      endcase
      hit = run && res_valid && res;
      det = hit || res_ocp || res_otp;
      fl = (hit && !msk) || (res_ocp && !test_mask[3]) || (res_otp && !test_mask[4]);
      done = run && (res_valid || m_t == TMO - 1);
      cancel = !diag_cont || !diag_en;
      fire = !run && m_per && (m_p == PER - 1) && !cancel;
      if (cr) begin
        m_step = 0; m_boot = 0; m_per = 0; m_fault = 0; m_dis = 0; m_t = 0; m_p = 0;
      end else begin
        if (fl) m_fault = 1;
        if (det) m_dis = 1;
        nt = (det || !run || done) ? 0 : m_t + 1;
        np = (det || run || er || fire) ? 0 : (m_per ? m_p + 1 : m_p);
        if (det) begin
          m_step = 0; m_boot = 0; m_per = 0;
        end else if (run) begin
          if (done) begin
            if (m_step == 1) m_step = 2;
            else if (m_step == 2 && m_open) m_step = 3;
            else begin m_step = 0; m_boot = 0; end
          end
          if (cancel) m_per = 0;
        end else if (er) begin
          m_step = 1; m_open = 1; m_per = diag_cont;
        end else begin
          if (fire) begin m_step = 1; m_open = 0; end
          if (cancel) m_per = 0;
        end
        m_t = nt; m_p = np;
      end
      m_en_d = diag_en; m_clr_d = diag_clr;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 amp_sd vs model", amp_sd, m_boot);
      chk("R3 test_step vs model", test_step, m_step);
      chk("R7 out_dis vs model", out_dis, m_dis);
      chk("R8 fault_n vs model", fault_n, !m_fault);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic valid(input int n, input bit r, input bit s, input bit o);
    res_valid = 1; res_rail = r; res_short = s; res_open = o;
    tick(n);
    res_valid = 0; res_rail = 0; res_short = 0; res_open = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(2); rst_n = 1;
  endtask

  task automatic clr_pulse();
    diag_clr = 1; tick(); diag_clr = 0; tick();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    chk("R1 reset amp_sd", amp_sd, 1);
    chk("R1 reset first step", test_step, 1);
    chk("R1 reset fault_n", fault_n, 1);
    chk("R1 reset out_dis", out_dis, 0);
    valid(3, 0, 0, 0);
    chk("R1 power-up run ends", test_step, 0);
    chk("R1 shutdown released", amp_sd, 0);

    // R3: timeouts
    do_reset();
    tick(3 * TMO - 1);
    chk("R3 open step after two timeouts", test_step, 3);
    tick();
    chk("R3 idle after timeouts", test_step, 0);
    chk("R3 timeout no fault", fault_n, 1);

    // R2: early termination
    do_reset();
    tick(2);
    diag_clr = 1; tick();
    chk("R2 run ended", test_step, 0);
    chk("R2 shutdown released", amp_sd, 0);
    diag_clr = 0; tick();

    // R4 / R5: one-shot, edge-armed
    diag_en = 1; tick();
    chk("R4 edge starts run", test_step, 1);
    diag_en = 0; tick();
    diag_en = 1; tick();
    valid(3, 0, 0, 0);
    chk("R4 busy edge dropped", test_step, 0);
    tick(40);
    chk("R5 level does not rerun", test_step, 0);
    diag_en = 0; tick();
    diag_en = 1; tick();
    chk("R5 new edge reruns", test_step, 1);
    valid(3, 0, 0, 0);
    diag_en = 0; tick();

    // R6: continuous
    diag_cont = 1; tick();
    diag_en = 1; tick();
    chk("R6 start", test_step, 1);
    valid(3, 0, 0, 0);
    chk("R6 first run done", test_step, 0);
    tick(PER - 1);
    chk("R6 still waiting", test_step, 0);
    tick();
    chk("R6 periodic start", test_step, 1);
    valid(2, 0, 0, 0);
    chk("R6 no open step", test_step, 0);
    diag_cont = 0; tick();
    tick(PER + 5);
    chk("R6 stopped by cont low", test_step, 0);
    diag_en = 0; tick();

    // R7 / R8 / R10 / R11
    test_mask = 5'b00000;
    diag_en = 1; tick();
    valid(1, 1, 0, 0);
    chk("R7 rail fault disables", out_dis, 1);
    chk("R8 rail fault flags", fault_n, 0);
    chk("R7 run ended", test_step, 0);
    diag_en = 0; tick(); diag_en = 1; tick();
    valid(3, 0, 0, 0);
    chk("R10 flag held", fault_n, 0);
    chk("R10 disable held", out_dis, 1);
    diag_en = 0;
    diag_clr = 1; tick();
    chk("R11 clear flag", fault_n, 1);
    chk("R11 clear disable", out_dis, 0);
    res_ocp = 1; tick(); res_ocp = 0; tick();
    chk("R9 idle ocp flag", fault_n, 0);
    chk("R11 held level no clear", out_dis, 1);
    diag_clr = 0; tick();
    clr_pulse();
    chk("R11 second clear", fault_n, 1);

    // R8 masks
    test_mask = 5'b00100;
    diag_en = 1; tick();
    valid(1, 1, 0, 0);
    chk("R8 masked rail disables", out_dis, 1);
    chk("R8 masked rail no flag", fault_n, 1);
    diag_en = 0; tick(); clr_pulse();
    test_mask = 5'b00001;
    diag_en = 1; tick();
    valid(1, 0, 0, 0);
    valid(1, 0, 1, 0);
    chk("R8 masked pair disables", out_dis, 1);
    chk("R8 masked pair no flag", fault_n, 1);
    diag_en = 0; tick(); clr_pulse();
    test_mask = 5'b00000;
    diag_en = 1; tick();
    valid(2, 0, 0, 0);
    valid(1, 0, 0, 1);
    chk("R7 open fault flags", fault_n, 0);
    diag_en = 0; tick(); clr_pulse();
    test_mask = 5'b10000;
    res_otp = 1; tick(); res_otp = 0;
    chk("R9 otp disables", out_dis, 1);
    chk("R8 otp masked no flag", fault_n, 1);
    tick(); clr_pulse();

    // R6: fault stops repetition
    test_mask = 5'b00000;
    diag_cont = 1; tick();
    diag_en = 1; tick();
    valid(3, 0, 0, 0);
    tick(PER);
    chk("R6 periodic run", test_step, 1);
    valid(1, 0, 0, 0);
    valid(1, 0, 1, 0);
    chk("R7 pair fault flags", fault_n, 0);
    tick(PER + 5);
    chk("R6 stopped by fault", test_step, 0);
    diag_en = 0; diag_cont = 0; tick();

    // R11 clear priority
    diag_clr = 1; res_ocp = 1; tick();
    chk("R11 clear wins flag", fault_n, 1);
    chk("R11 clear wins disable", out_dis, 0);
    res_ocp = 0; diag_clr = 0; tick(2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule